// File: doc/BRIEF.md
# Strap-configured power-up init sequencer

This block brings a radar front end's control registers into a known state after every reset. First it waits a settling interval, counted in timebase ticks, so that the external configuration straps can settle. It then captures four 2-bit strap codes in one cycle. The first strap selects the operating mode. From that mode the block issues a fixed, timed series of writes to the two direct-access control registers. The strap codes arrive already digitized. The analog blocks are represented only by the enable bits in those registers.

The two autonomous modes share most of the series. They switch the analog blocks off one by one, with a fixed dwell after each step. They then turn the baseband sampling on and wait for the baseband to settle. Each mode then writes its own final value for control register 1. The two SPI modes only write zero to both registers and stop. The captured strap codes stay available for a status read-back. The block also reports whether the external reference clock was requested.

Writes leave the block on a valid/ready channel. A write is transferred at a rising edge where `wr_valid_o` and `wr_ready_i` are both high. While `wr_ready_i` is low, the offered write stays in place unchanged. Back-pressure only stretches the series and never drops or reorders a write. The settle and dwell waits are parameters, counted in ticks or cycles, so a test can shorten them.

Top module: `radar_boot_seq`

## Requirements
- R1: In reset and after reset release, `strap_o` reads 0 and no write is offered. `strap_o` loads `strap_i` in the cycle in which the SETTLE_TICKS-th `tick_i` pulse after release is seen. The value on `strap_i` in any other cycle has no effect, and no write is offered before this capture.
- R2: Strap one is `strap_i[1:0]`. Its codes are 00 for autonomous CW, 01 for autonomous pulsed, 10 for SPI with the external clock, and 11 for SPI without it. After capture, `ext_clk_en_o` is 1 only when the captured code is 10, and it is 0 before capture.
- R3: In both SPI modes exactly two writes are made: address 0 with data 0x0000, then address 1 with data 0x0000.
- R4: In both autonomous modes the series opens with five writes to address 0. Their data are 0x000F, 0x0007, 0x0003, 0x0001 and 0x0000. Register 0 holds the sample-and-hold enable in bit 4, the power amplifier in bit 3, the PLL in bit 2, the divider bias in bit 1 and the RF enable in bit 0, and these blocks are cleared in that order from an all-on value of 0x001F.
- R5: After each of the five shutdown writes is accepted, `wr_valid_o` stays low for exactly STEP_CYCLES clock cycles. Only then is the next write offered.
- R6: After the shutdown writes, address 1 is written with 0x1037 to enable baseband sampling. The next write is then offered in the cycle after the BB_TICKS-th `tick_i` pulse that follows its acceptance.
- R7: The last write of an autonomous series goes to address 1. Its data is 0x10B3 in CW mode and 0x0092 in pulsed mode.
- R8: An offered write keeps `wr_valid_o` high and holds `wr_addr_o` and `wr_data_o` stable until it is accepted.
- R9: `init_done_o` goes high in the cycle in which the last write of the series is accepted, and stays high until reset. No write is offered after it.
- R10: `strap_o` and `ext_clk_en_o` keep their captured values until the next reset, whatever `strap_i` does afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase pulse, one cycle wide, that drives the settle and baseband waits |
| strap_i | input | 8 | Digitized strap codes, strap k in bits [2k-1:2k-2] |
| wr_valid_o | output | 1 | A register write is offered |
| wr_ready_i | input | 1 | The register side accepts the offered write |
| wr_addr_o | output | 1 | Target register: 0 or 1 |
| wr_data_o | output | 16 | Data for the target register |
| init_done_o | output | 1 | The sequence is complete |
| strap_o | output | 8 | Captured strap codes |
| ext_clk_en_o | output | 1 | External reference clock requested |

## Verification
The hardest case to reach from the ports is proving that the straps are sampled in exactly one cycle, the one that ends the settling wait. The bench drives the bitwise complement of the intended code on `strap_i` at every other time. It presents the true code only in the cycle that carries the final settle tick, so a capture one cycle early or late selects the wrong mode and shows up in the write series. The bench sweeps all 256 strap codes. On alternate runs it stalls `wr_ready_i`, so that dwell counting and write holding are also exercised under back-pressure.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  localparam int unsigned STRAP_CODE_W = 2;
  localparam int unsigned REG_W        = 16;

  typedef enum logic [STRAP_CODE_W-1:0] {
    MODE_AUTO_CW    = 2'b00,
    MODE_AUTO_PULSE = 2'b01,
    MODE_SPI_XCLK   = 2'b10,
    MODE_SPI_NOCLK  = 2'b11
  } boot_mode_e;

  typedef enum logic [3:0] {
    ST_SETTLE,
    ST_SD_WR,
    ST_SD_HOLD,
    ST_BB_WR,
    ST_BB_WAIT,
    ST_FIN_WR,
    ST_SPI_R0,
    ST_SPI_R1,
    ST_DONE
  } boot_state_e;

  localparam logic [REG_W-1:0] R0_POWERUP  = 16'h001F;
  localparam logic [REG_W-1:0] R1_BB_ON    = 16'h1037;
  localparam logic [REG_W-1:0] R1_PULSED   = 16'h0092;
  localparam logic [REG_W-1:0] R1_CW       = 16'h10B3;
  localparam logic [REG_W-1:0] REG_ALL_OFF = 16'h0000;

endpackage

// File: rtl/boot_tick_timer.sv
module boot_tick_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);

  logic [CNT_W-1:0] cnt_q;

  // The hit comes on the limit_i-th counted step; the count then restarts at zero.
  assign hit_o = step_i && (cnt_q == (limit_i - CNT_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (hit_o) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R5, R6: while counting, the count never reaches the selected limit
  p_cnt_in_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (cnt_q < limit_i));

endmodule

// File: rtl/boot_strap_latch.sv
module boot_strap_latch
  import boot_seq_pkg::*;
#(
  parameter int unsigned N_STRAPS = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               load_i,
  input  logic [N_STRAPS*STRAP_CODE_W-1:0]   strap_i,
  output logic [N_STRAPS*STRAP_CODE_W-1:0]   strap_o,
  output logic                               captured_o,
  output boot_mode_e                         mode_o,
  output logic                               ext_clk_en_o
);

  localparam int unsigned SW = N_STRAPS * STRAP_CODE_W;

  logic [SW-1:0] strap_q;
  logic          cap_q;
  logic          xclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q <= '0;
      cap_q   <= 1'b0;
      xclk_q  <= 1'b0;
    end else if (load_i && !cap_q) begin
      strap_q <= strap_i;
      cap_q   <= 1'b1;
      xclk_q  <= (strap_i[STRAP_CODE_W-1:0] == MODE_SPI_XCLK);
    end
  end

  assign strap_o      = strap_q;
  assign captured_o   = cap_q;
  assign mode_o       = boot_mode_e'(strap_q[STRAP_CODE_W-1:0]);
  assign ext_clk_en_o = xclk_q;

  // R10: once captured, the codes and the flag are frozen
  p_strap_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_q |=> (cap_q && $stable(strap_q) && $stable(xclk_q)));

  // R2: the external clock request matches the captured first strap
  p_xclk_matches_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xclk_q |-> (cap_q && strap_q[STRAP_CODE_W-1:0] == MODE_SPI_XCLK));

endmodule

// File: rtl/boot_shutdown_chain.sv
module boot_shutdown_chain
  import boot_seq_pkg::*;
#(
  parameter int unsigned       N_BLK = 5,
  parameter int unsigned       IDX_W = 3,
  parameter logic [REG_W-1:0]  START = R0_POWERUP,
  parameter logic [N_BLK*4-1:0] ORDER = 20'h01234
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [REG_W-1:0] word_o
);

  // Stage g holds the register-0 word after the first g+1 blocks are off.
  logic [REG_W-1:0] stage [N_BLK];

  for (genvar g = 0; g < N_BLK; g++) begin : g_stage
    localparam int unsigned BITP = int'(ORDER[g*4 +: 4]);
    if (g == 0) begin : g_first
      assign stage[g] = START & ~(REG_W'(1) << BITP);
    end else begin : g_next
      assign stage[g] = stage[g-1] & ~(REG_W'(1) << BITP);
    end
  end

  always_comb begin
    word_o = REG_ALL_OFF;
    for (int i = 0; i < N_BLK; i++) begin
      if (idx_i == IDX_W'(i)) word_o = stage[i];
    end
  end

endmodule

// File: rtl/radar_boot_seq.sv
module radar_boot_seq
  import boot_seq_pkg::*;
#(
  parameter int unsigned        N_STRAPS     = 4,
  parameter int unsigned        SETTLE_TICKS = 200,
  parameter int unsigned        BB_TICKS     = 5000,
  parameter int unsigned        STEP_CYCLES  = 13,
  parameter int unsigned        N_BLK        = 5,
  parameter logic [N_BLK*4-1:0] SD_ORDER     = 20'h01234
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             tick_i,
  input  logic [N_STRAPS*STRAP_CODE_W-1:0] strap_i,
  output logic                             wr_valid_o,
  input  logic                             wr_ready_i,
  output logic                             wr_addr_o,
  output logic [REG_W-1:0]                 wr_data_o,
  output logic                             init_done_o,
  output logic [N_STRAPS*STRAP_CODE_W-1:0] strap_o,
  output logic                             ext_clk_en_o
);

  localparam int unsigned MAX_A   = (SETTLE_TICKS > BB_TICKS) ? SETTLE_TICKS : BB_TICKS;
  localparam int unsigned MAX_LIM = (MAX_A > STEP_CYCLES) ? MAX_A : STEP_CYCLES;
  localparam int unsigned CNT_W   = $clog2(MAX_LIM + 1);
  localparam int unsigned IDX_W   = $clog2(N_BLK + 1);

  boot_state_e      state_q, state_d;
  logic [IDX_W-1:0] sd_idx_q, sd_idx_d;
  logic             t_step, t_hit;
  logic [CNT_W-1:0] t_limit;
  logic             cap_load, cap_done;
  boot_mode_e       cap_mode, live_mode;
  logic [REG_W-1:0] sd_word;
  logic             last_acc;

  boot_tick_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (t_step),
    .limit_i(t_limit),
    .hit_o  (t_hit)
  );

  boot_strap_latch #(.N_STRAPS(N_STRAPS)) i_straps (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (cap_load),
    .strap_i     (strap_i),
    .strap_o     (strap_o),
    .captured_o  (cap_done),
    .mode_o      (cap_mode),
    .ext_clk_en_o(ext_clk_en_o)
  );

  boot_shutdown_chain #(
    .N_BLK(N_BLK),
    .IDX_W(IDX_W),
    .START(R0_POWERUP),
    .ORDER(SD_ORDER)
  ) i_chain (
    .idx_i (sd_idx_q),
    .word_o(sd_word)
  );

  assign live_mode = boot_mode_e'(strap_i[STRAP_CODE_W-1:0]);

  always_comb begin
    state_d    = state_q;
    sd_idx_d   = sd_idx_q;
    t_step     = 1'b0;
    t_limit    = '0;
    cap_load   = 1'b0;
    wr_valid_o = 1'b0;
    wr_addr_o  = 1'b0;
    wr_data_o  = REG_ALL_OFF;
    last_acc   = 1'b0;
    unique case (state_q)
      ST_SETTLE: begin
        t_step  = tick_i;
        t_limit = CNT_W'(SETTLE_TICKS);
        if (t_hit) begin
          cap_load = 1'b1;
          if (live_mode == MODE_SPI_XCLK || live_mode == MODE_SPI_NOCLK) begin
            state_d = ST_SPI_R0;
          end else begin
            state_d = ST_SD_WR;
          end
        end
      end
      ST_SD_WR: begin
        wr_valid_o = 1'b1;
        wr_data_o  = sd_word;
        if (wr_ready_i) state_d = ST_SD_HOLD;
      end
      ST_SD_HOLD: begin
        t_step  = 1'b1;
        t_limit = CNT_W'(STEP_CYCLES);
        if (t_hit) begin
          if (sd_idx_q == IDX_W'(N_BLK - 1)) begin
            state_d = ST_BB_WR;
          end else begin
            sd_idx_d = sd_idx_q + IDX_W'(1);
            state_d  = ST_SD_WR;
          end
        end
      end
      ST_BB_WR: begin
        wr_valid_o = 1'b1;
        wr_addr_o  = 1'b1;
        wr_data_o  = R1_BB_ON;
        if (wr_ready_i) state_d = ST_BB_WAIT;
      end
      ST_BB_WAIT: begin
        t_step  = tick_i;
        t_limit = CNT_W'(BB_TICKS);
        if (t_hit) state_d = ST_FIN_WR;
      end
      ST_FIN_WR: begin
        wr_valid_o = 1'b1;
        wr_addr_o  = 1'b1;
        wr_data_o  = (cap_mode == MODE_AUTO_CW) ? R1_CW : R1_PULSED;
        if (wr_ready_i) begin
          last_acc = 1'b1;
          state_d  = ST_DONE;
        end
      end
      ST_SPI_R0: begin
        wr_valid_o = 1'b1;
        if (wr_ready_i) state_d = ST_SPI_R1;
      end
      ST_SPI_R1: begin
        wr_valid_o = 1'b1;
        wr_addr_o  = 1'b1;
        if (wr_ready_i) begin
          last_acc = 1'b1;
          state_d  = ST_DONE;
        end
      end
      default: begin
        state_d = ST_DONE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_SETTLE;
      sd_idx_q <= '0;
    end else begin
      state_q  <= state_d;
      sd_idx_q <= sd_idx_d;
    end
  end

  assign init_done_o = (state_q == ST_DONE) || last_acc;

  // R8: an offered write holds until accepted
  p_wr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  // R9: completion is sticky
  p_done_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  // R9: nothing is offered after completion
  p_quiet_after_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> !wr_valid_o);

  // R1: no write before the straps are captured
  p_no_wr_before_cap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_done |-> !wr_valid_o);

  // R5: the dwell after a shutdown write starts with the channel idle
  p_dwell_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SD_WR && wr_ready_i) |=> !wr_valid_o);

endmodule

// File: tb/test_radar_boot_seq.sv
module test_radar_boot_seq;

  localparam int S_T  = 3;
  localparam int B_T  = 4;
  localparam int STEP = 3;
  localparam int TDIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        ready = 1'b0;
  logic [7:0]  strap = 8'h00;
  logic        wr_valid, wr_addr, init_done, ext_clk;
  logic [15:0] wr_data;
  logic [7:0]  strap_cap;

  always #4 clk = ~clk;

  radar_boot_seq #(
    .SETTLE_TICKS(S_T),
    .BB_TICKS    (B_T),
    .STEP_CYCLES (STEP)
  ) i_radar_boot_seq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tick_i      (tick),
    .strap_i     (strap),
    .wr_valid_o  (wr_valid),
    .wr_ready_i  (ready),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .init_done_o (init_done),
    .strap_o     (strap_cap),
    .ext_clk_en_o(ext_clk)
  );

  int n_chk = 0, n_fail = 0, total = 0;
  int cyc, ticks_drv, run, wcnt, done_wcnt, post, lim;
  bit wd, cap_pending, prev_stall, offered, done_seen;
  logic [7:0]  cur_code;
  logic        p_addr;
  logic [15:0] p_data;
  logic        wl_a [16];
  logic [15:0] wl_d [16];
  int gap [16];
  int tgap [16];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s (run %0d) actual=%0h expected=%0h", req, what, run, act, exp);
    end
  endtask

  task automatic monitor();
    if (cap_pending) begin
      chk(strap_cap == cur_code, "R1", "strap captured", int'(strap_cap), int'(cur_code));
      chk(ext_clk == (cur_code[1:0] == 2'b10), "R2", "ext clock after capture",
          int'(ext_clk), int'(cur_code[1:0] == 2'b10));
      cap_pending = 1'b0;
    end
    if (tick && ticks_drv == S_T) begin
      chk(strap_cap == 8'h00 && !ext_clk, "R1", "nothing captured before settle end",
          int'(strap_cap), 0);
      cap_pending = 1'b1;
    end
    if (prev_stall) begin
      chk(wr_valid && wr_addr == p_addr && wr_data == p_data, "R8", "stalled write held",
          int'({wr_valid, wr_addr, wr_data}), int'({1'b1, p_addr, p_data}));
    end
    if (wr_valid && !offered) begin
      offered = 1'b1;
      chk(ticks_drv >= S_T, "R1", "first write after capture", ticks_drv, S_T);
    end
    if (wcnt > 0 && wcnt <= 16 && !wr_valid) begin
      gap[wcnt-1]++;
      if (tick) tgap[wcnt-1]++;
    end
    if (init_done && !done_seen) begin
      done_seen = 1'b1;
      chk(wr_valid && ready, "R9", "done rises with last handshake",
          int'(wr_valid && ready), 1);
    end
    if (wr_valid && ready) begin
      if (wcnt < 16) begin
        wl_a[wcnt] = wr_addr;
        wl_d[wcnt] = wr_data;
      end
      wcnt++;
      if (init_done) done_wcnt = wcnt;
    end
    prev_stall = wr_valid && !ready;
    p_addr = wr_addr;
    p_data = wr_data;
  endtask

  task automatic step_cycle();
    @(negedge clk);
    total++;
    if (total > 150000) wd = 1'b1;
    if (rst_n) begin
      cyc++;
      tick = (cyc % TDIV == TDIV - 1);
      if (tick) ticks_drv++;
      strap = (tick && ticks_drv == S_T) ? cur_code : ~cur_code;
    end else begin
      tick  = 1'b0;
      strap = ~cur_code;
    end
    ready = (run % 2 == 0) ? 1'b1 : (((cyc + run) % 3) != 0);
    #3;
    if (rst_n) monitor();
  endtask

  task automatic start_run();
    rst_n = 1'b0;
    cyc = 0; ticks_drv = 0; wcnt = 0; done_wcnt = -1; post = 0; lim = 0;
    cap_pending = 1'b0; prev_stall = 1'b0; offered = 1'b0; done_seen = 1'b0;
    for (int i = 0; i < 16; i++) begin
      gap[i] = 0;
      tgap[i] = 0;
      wl_a[i] = 1'b0;
      wl_d[i] = 16'h0;
    end
    for (int i = 0; i < 3; i++) step_cycle();
    chk(!wr_valid && !init_done && strap_cap == 8'h00 && !ext_clk, "R1", "reset state",
        int'({wr_valid, init_done, ext_clk, strap_cap}), 0);
    rst_n = 1'b1;
  endtask

  task automatic end_checks();
    bit spi;
    int n_exp;
    logic        ea;
    logic [15:0] ed;
    spi   = cur_code[1];
    n_exp = spi ? 2 : 7;
    chk(wcnt == n_exp, spi ? "R3" : "R4", "write count", wcnt, n_exp);
    for (int i = 0; i < n_exp && i < wcnt; i++) begin
      if (spi) begin
        ea = (i == 1);
        ed = 16'h0000;
      end else if (i < 5) begin
        ea = 1'b0;
        ed = 16'h001F >> (i + 1);
      end else if (i == 5) begin
        ea = 1'b1;
        ed = 16'h1037;
      end else begin
        ea = 1'b1;
        ed = (cur_code[1:0] == 2'b00) ? 16'h10B3 : 16'h0092;
      end
      chk(wl_a[i] == ea && wl_d[i] == ed,
          spi ? "R3" : (i < 5 ? "R4" : (i == 5 ? "R6" : "R7")),
          "write address/data", int'({wl_a[i], wl_d[i]}), int'({ea, ed}));
    end
    if (!spi) begin
      for (int i = 0; i < 5; i++) begin
        chk(gap[i] == STEP, "R5", "shutdown dwell", gap[i], STEP);
      end
      chk(tgap[5] == B_T, "R6", "baseband settle ticks", tgap[5], B_T);
    end
    chk(done_wcnt == n_exp, "R9", "done at last write", done_wcnt, n_exp);
    chk(init_done == 1'b1, "R9", "done stays high", int'(init_done), 1);
    chk(strap_cap == cur_code, "R10", "straps retained", int'(strap_cap), int'(cur_code));
    chk(ext_clk == (cur_code[1:0] == 2'b10), "R10", "clock request retained",
        int'(ext_clk), int'(cur_code[1:0] == 2'b10));
  endtask

  initial begin
    wd = 1'b0;
    for (int r = 0; r < 256 && !wd; r++) begin
      run = r;
      cur_code = 8'(r);
      start_run();
      while (!(done_seen && post >= 15) && lim < 800 && !wd) begin
        step_cycle();
        lim++;
        if (done_seen) post++;
      end
      if (!done_seen) chk(1'b0, "R9", "sequence completed", 0, 1);
      end_checks();
    end
    if (wd) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R9 run did not end actual=%0d expected=%0d", total, 150000);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule